// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator

This block produces two pulse-width modulated outputs from a shared bus clock. Software programs it through a small synchronous write port (address, data, write strobe). Each of the two 8-bit channels has its own period, duty, polarity, alignment and enable settings. One shared 3-bit prescaler sets how many bus cycles make one counting step.

Each channel counts in one of two ways. In edge (left-aligned) mode the counter runs up and then wraps. In symmetric (center-aligned) mode it runs up and then back down, so the active pulse sits in the middle of the period. Period and duty writes go into a shadow copy, and a channel picks them up only at a period boundary. A change therefore never cuts a pulse short or adds a stray one.

A join bit turns the two channels into one 16-bit modulator. Channel 0 supplies the high byte of the period and duty, and channel 1 supplies the low byte. The joined output appears on pin 1 only, and pin 0 is held low.

Top module: `pwm_dual`

## Requirements
- R1: Register map at `wr_addr`: 0 = prescaler select in bits [2:0]; 1 = control; 2 = channel 0 period; 3 = channel 1 period; 4 = channel 0 duty; 5 = channel 1 duty. Control bits: [0] enable ch0, [1] enable ch1, [2] polarity ch0, [3] polarity ch1, [4] symmetric ch0, [5] symmetric ch1, [6] join.
- R2: A prescaler select value n makes the channel counters advance once every 2^n bus cycles, for n from 0 to 7.
- R3: In edge mode with period P > 0 and duty D, the output repeats every P·2^n bus cycles and is active for min(D,P)·2^n of them.
- R4: With polarity 1 the active level is high and the period starts active. With polarity 0 the output is the inverse: it starts low and goes high at the duty match.
- R5: In symmetric mode with P > 0, the counter goes 0..P-1 and then P-1..0. Each value is held for one step per direction, so the output repeats every 2·P·2^n cycles and is active for 2·min(D,P)·2^n of them.
- R6: A duty of 0 keeps an enabled channel at its inactive level. A duty of P or more keeps it at its active level.
- R7: A period of 0 holds an enabled channel at its inactive level, which is the inverse of its polarity bit.
- R8: Period and duty writes made while a channel is enabled take effect only when the current period ends.
- R9: A disabled channel drives its pin low and holds its counter at 0. Re-enabling it starts a new period from count 0, and a channel with nonzero duty is active in the first cycle after the enable write.
- R10: With join set, {period0, period1} and {duty0, duty1} form the 16-bit period and duty. The channel 1 enable, polarity and symmetric bits govern the joined output, which drives pin 1.
- R11: With join set, pin 0 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 2 | Modulated outputs, bit 0 = channel 0, bit 1 = channel 1 or joined |

## Verification
The bench checks duty 0, duty at or above the period, and period 0. A design with an off-by-one compare would leave a one-step spike at these edges, and a missing period-0 guard would let the counter wrap on nonsense values. It rewrites the duty in the middle of a period. Unbuffered logic would then raise the pin again before the period boundary. It re-enables a stopped channel and expects the active level at once. A counter that is not cleared would resume part way through a period. In the joined cases it checks the byte order and that pin 0 stays silent. Swapped bytes would give a completely different period, and a leaking channel 0 would toggle pin 0.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_PRESC = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
   localparam logic [ADDR_W-1:0] A_PER0  = 3'd2;
   localparam logic [ADDR_W-1:0] A_PER1  = 3'd3;
   localparam logic [ADDR_W-1:0] A_DTY0  = 3'd4;
   localparam logic [ADDR_W-1:0] A_DTY1  = 3'd5;
   localparam int unsigned CTRL_W = 7;
   localparam int unsigned B_EN  = 0;  // bits 0,1
   localparam int unsigned B_POL = 2;  // bits 2,3
   localparam int unsigned B_SYM = 4;  // bits 4,5
   localparam int unsigned B_CAT = 6;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned DIV_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("pwm_prescale: SEL_W out of range");
   end

   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   one_hot;
   logic [DIV_W-1:0] mask;

   always_comb begin
      one_hot = (DIV_W+1)'(1) << sel;
      mask    = DIV_W'(one_hot - 1'b1);
   end

   // a step every 2^sel cycles: all masked counter bits set
   assign tick = &(cnt | ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   // R2: with a division above 1, two steps never come back to back
   a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel != '0) |=> (!tick || sel == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         en,
   input  logic         pol,
   input  logic         center,
   input  logic [W-1:0] per_in,
   input  logic [W-1:0] dty_in,
   output logic         pwm
);
   if (W < 2 || W > 32) begin : g_bad_w
      $error("pwm_chan: W out of range");
   end

   logic [W-1:0] cnt, per_q, dty_q;
   logic         down;
   logic         at_top, active;

   assign at_top = cnt >= (per_q - 1'b1);
   assign active = (dty_q >= per_q) || (cnt < dty_q);
   assign pwm    = en & ((per_q == '0) ? ~pol : (active ? pol : ~pol));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         down  <= 1'b0;
         per_q <= '0;
         dty_q <= '0;
      end else if (!en) begin
         cnt   <= '0;
         down  <= 1'b0;
         per_q <= per_in;
         dty_q <= dty_in;
      end else if (tick) begin
         if (per_q == '0) begin
            cnt   <= '0;
            down  <= 1'b0;
            per_q <= per_in;
            dty_q <= dty_in;
         end else if (!center) begin
            down <= 1'b0;
            if (at_top) begin
               cnt   <= '0;
               per_q <= per_in;
               dty_q <= dty_in;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (!down) begin
            if (at_top) down <= 1'b1;
            else        cnt  <= cnt + 1'b1;
         end else begin
            if (cnt == '0) begin
               down  <= 1'b0;
               per_q <= per_in;
               dty_q <= dty_in;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R9: a disabled channel restarts from zero
   a_r9_dis_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt == '0);
   // R3: edge mode counter stays below the period
   a_r3_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !center && !down && per_q != '0) |-> cnt < per_q);
   // R5: symmetric counter never passes the top value
   a_r5_ctr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (en && center && per_q != '0) |-> cnt <= per_q - 1'b1);
   // R8: no shadow reload without a counting step
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> ($stable(per_q) && $stable(dty_q)));
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
   import pwm_pkg::*;
#(
   parameter int unsigned CH_W  = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CH_W-1:0]   wr_data,
   output logic [1:0]        pwm_o
);
   localparam int unsigned N_CH  = 2;
   localparam int unsigned CAT_W = 2 * CH_W;

   if (CH_W < CTRL_W || SEL_W > CH_W) begin : g_bad_cfg
      $error("pwm_dual: CH_W too narrow for the control register");
   end

   logic [SEL_W-1:0]  presc_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CH_W-1:0]   per_q [N_CH];
   logic [CH_W-1:0]   dty_q [N_CH];
   logic              tick, cat, cat_out;
   logic [N_CH-1:0]   ch_out;

   // R1: register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
         ctrl_q  <= '0;
         for (int i = 0; i < N_CH; i++) begin
            per_q[i] <= '0;
            dty_q[i] <= '0;
         end
      end else if (wr_en) begin
         case (wr_addr)
            A_PRESC: presc_q  <= wr_data[SEL_W-1:0];
            A_CTRL:  ctrl_q   <= wr_data[CTRL_W-1:0];
            A_PER0:  per_q[0] <= wr_data;
            A_PER1:  per_q[1] <= wr_data;
            A_DTY0:  dty_q[0] <= wr_data;
            A_DTY1:  dty_q[1] <= wr_data;
            default: ;
         endcase
      end
   end

   assign cat = ctrl_q[B_CAT];

   pwm_prescale #(.SEL_W(SEL_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .sel(presc_q), .tick(tick));

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      pwm_chan #(.W(CH_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .en     (ctrl_q[B_EN+g] & ~cat),
         .pol    (ctrl_q[B_POL+g]),
         .center (ctrl_q[B_SYM+g]),
         .per_in (per_q[g]),
         .dty_in (dty_q[g]),
         .pwm    (ch_out[g]));
   end

   // R10: joined channel, high byte from channel 0, controls from channel 1
   pwm_chan #(.W(CAT_W)) u_cat (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .en     (cat & ctrl_q[B_EN+1]),
      .pol    (ctrl_q[B_POL+1]),
      .center (ctrl_q[B_SYM+1]),
      .per_in ({per_q[0], per_q[1]}),
      .dty_in ({dty_q[0], dty_q[1]}),
      .pwm    (cat_out));

   assign pwm_o[0] = ch_out[0];
   assign pwm_o[1] = cat ? cat_out : ch_out[1];

   // R11: joined mode leaves pin 0 low
   a_r11_pin0_low: assert property (@(posedge clk) disable iff (!rst_n)
      cat |-> pwm_o[0] == 1'b0);
   // R9: both channels off means both pins low
   a_r9_all_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[B_EN+1:B_EN] == 2'b00) |-> pwm_o == 2'b00);
endmodule

// File: tb/tb_pwm_dual.sv
module tb_pwm_dual;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] pwm_o;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   pwm_dual dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .pwm_o(pwm_o));

   typedef struct packed {
      logic        ch;
      logic        cat;
      logic [2:0]  ps;
      logic        pol;
      logic        sym;
      logic [15:0] per;
      logic [15:0] dty;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 16'd10,  16'd3},
      '{1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 16'd8,   16'd2},
      '{1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 16'd6,   16'd2},
      '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 16'd5,   16'd4},
      '{1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 16'd7,   16'd0},
      '{1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 16'd7,   16'd9},
      '{1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'd0,   16'd3},
      '{1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 16'd260, 16'd80},
      '{1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 16'd258, 16'd257},
      '{1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 16'd2,   16'd1}
   };

   function automatic string vtag(input int i);
      case (i)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R5";
         4: return "R6";
         5: return "R6";
         6: return "R7";
         7: return "R10";
         8: return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_hi(input int pin, input int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_o[pin]) hi++;
      end
   endtask

   initial begin
      int t_cyc, steps, act, hi_exp, hi, tgt, oth, p, d;
      logic [7:0] ctrl;
      logic [7:0] pat;
      repeat (3) @(negedge clk);
      check("R9 reset", int'(pwm_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 after reset", int'(pwm_o), 0);

      // R1 register map exercised by every configuration below
      for (int i = 0; i < NV; i++) begin
         vec_t v = VEC[i];
         p = int'(v.per); d = int'(v.dty);
         wr(3'd1, 8'h00);
         wr(3'd0, {5'd0, v.ps});
         if (v.cat) begin
            wr(3'd2, v.per[15:8]); wr(3'd3, v.per[7:0]);
            wr(3'd4, v.dty[15:8]); wr(3'd5, v.dty[7:0]);
            ctrl = 8'h40 | 8'h02 | ({7'd0, v.pol} << 3) | ({7'd0, v.sym} << 5);
         end else if (v.ch == 1'b0) begin
            wr(3'd2, v.per[7:0]); wr(3'd4, v.dty[7:0]);
            ctrl = 8'h01 | ({7'd0, v.pol} << 2) | ({7'd0, v.sym} << 4);
         end else begin
            wr(3'd3, v.per[7:0]); wr(3'd5, v.dty[7:0]);
            ctrl = 8'h02 | ({7'd0, v.pol} << 3) | ({7'd0, v.sym} << 5);
         end
         wr(3'd1, ctrl);
         if (p == 0) begin
            steps = 8; hi_exp = v.pol ? 0 : steps;
         end else begin
            act   = (d < p) ? d : p;
            steps = v.sym ? 2 * p : p;
            if (v.sym) act = 2 * act;
            hi_exp = v.pol ? act : steps - act;
         end
         t_cyc  = steps * (1 << v.ps);
         hi_exp = hi_exp * (1 << v.ps);
         tgt = (v.cat || v.ch) ? 1 : 0;
         oth = 1 - tgt;
         repeat (t_cyc) @(negedge clk);
         count_hi(tgt, 2 * t_cyc, hi);
         check(vtag(i), hi, 2 * hi_exp);
         count_hi(oth, t_cyc, hi);
         // R9 (other channel disabled) / R11 (pin 0 in joined mode)
         check(v.cat ? "R11" : "R9 idle pin", hi, 0);
      end

      // R8: duty rewritten mid-period waits for the boundary
      wr(3'd1, 8'h00);
      wr(3'd0, 8'd0);
      wr(3'd2, 8'd10);
      wr(3'd4, 8'd3);
      wr(3'd1, 8'h05);
      repeat (25) @(negedge clk);
      while (!(pwm_o[0] == 1'b1)) @(negedge clk);
      while (pwm_o[0] == 1'b1) @(negedge clk);
      while (pwm_o[0] == 1'b0) @(negedge clk);  // count 0 of a new period
      repeat (3) @(negedge clk);                 // count 3
      wr(3'd4, 8'd7);                            // now at count 4
      count_hi(0, 5, hi);
      check("R8 old duty kept", hi, 0);
      count_hi(0, 20, hi);
      check("R8 new duty applied", hi, 14);

      // R9: disable holds low, re-enable restarts at count 0
      wr(3'd1, 8'h00);
      count_hi(0, 6, hi);
      check("R9 disabled low", hi, 0);
      wr(3'd1, 8'h05);
      pat = '0;
      for (int k = 0; k < 8; k++) begin
         pat = {pat[6:0], pwm_o[0]};
         @(negedge clk);
      end
      check("R9 restart pattern", int'(pat), 8'hFE);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule